// File: doc/BRIEF.md
# Reorder Buffer with In-Order Commit

This block keeps every in-flight instruction of an out-of-order core in program order between dispatch and retirement. It is a circular queue. Dispatch allocates an entry at the tail and gets the entry index back as the instruction's tag. When execution finishes, the result is written back by tag into that entry, which marks it finished. Results may arrive in any order. Retirement only ever looks at the oldest entry. When that entry is finished, its result is released to the architected state and the oldest pointer moves one step forward.

Each entry is one of two kinds. A register-writing entry sends its value and destination register to the architected register file write port. A store entry sends its data and destination address to a memory write port. Because commits leave strictly from the oldest position, the outside world sees updates in program order. Dispatch is allowed only when a queue entry is free and the issue logic also reports a free reservation-station slot.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty. Neither write port is active, the first tag offered is 0, and `alloc_ready` equals `rs_avail`.
- R2: Every accepted allocation returns on `alloc_tag` the tail entry index. Tags count up from 0 in allocation order and wrap from DEPTH-1 back to 0.
- R3: `alloc_ready` is low while DEPTH entries are outstanding or while `rs_avail` is low. A request made while `alloc_ready` is low creates no entry and does not advance the tag.
- R4: Only the oldest entry may commit, and only once it is finished. Results written back out of order still commit in allocation order.
- R5: A finished entry allocated with `alloc_kind` = 0 (register) commits by raising `arf_we` for one cycle, with `arf_addr` = its destination and `arf_data` = its written-back value. `mem_we` stays low in that cycle.
- R6: A finished entry allocated with `alloc_kind` = 1 (store) commits by raising `mem_we` for one cycle, with `mem_addr` = its destination and `mem_data` = its written-back value. `arf_we` stays low in that cycle.
- R7: A writeback to the oldest entry does not commit in the cycle the writeback is presented. The commit appears in the following cycle.
- R8: At most one entry commits per cycle. Each commit frees exactly one entry, so a full buffer raises `alloc_ready` again after one commit.
- R9: An allocation and a commit in the same cycle both take effect, and the occupancy is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rs_avail | input | 1 | A reservation-station slot is free |
| alloc_valid | input | 1 | Dispatch requests an entry |
| alloc_kind | input | 1 | 0 = register write, 1 = store |
| alloc_dest | input | DEST_W | Destination register number or store address |
| alloc_ready | output | 1 | An allocation is accepted this cycle if requested |
| alloc_tag | output | TAG_W | Index of the entry being allocated |
| wb_valid | input | 1 | Execution result is present |
| wb_tag | input | TAG_W | Entry the result belongs to |
| wb_value | input | DATA_W | Result value or store data |
| arf_we | output | 1 | Register file write strobe from commit |
| arf_addr | output | DEST_W | Register number written |
| arf_data | output | DATA_W | Value written to the register file |
| mem_we | output | 1 | Memory write strobe from commit |
| mem_addr | output | DEST_W | Store address |
| mem_data | output | DATA_W | Store data |

## Verification
Allocation and commit can meet in the same cycle. The bench writes back the oldest entry and then, in the very cycle its commit shows on a write port, presents a new dispatch request. It checks that the commit strobe and `alloc_ready` are both high, that the new entry receives the next tag in sequence, and that later commits still leave in order. Writeback and commit can also coincide. The bench writes back the next entry while the current one is committing and judges by the order and the cycle in which each commit appears. A writeback to a waiting head entry must not commit until the following cycle.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic {
    KIND_REG   = 1'b0,
    KIND_STORE = 1'b1
  } rob_kind_e;

  // next index of a circular position, wrapping at depth
  function automatic int unsigned rob_step(input int unsigned idx, input int unsigned depth);
    return (idx + 1 == depth) ? 0 : idx + 1;
  endfunction

  // number of live entries from head/tail positions with wrap bits
  function automatic int unsigned rob_fill(input int unsigned h, input bit hw,
                                           input int unsigned t, input bit tw,
                                           input int unsigned depth);
    if (hw == tw) return t - h;
    return depth - h + t;
  endfunction

endpackage

// File: rtl/rob_ptr.sv
module rob_ptr #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] idx,
  output logic             wrap
);
  import rob_pkg::*;

  logic [IDX_W-1:0] idx_nx;
  logic             wrap_nx;

  always_comb begin
    idx_nx  = IDX_W'(rob_step(32'(idx), DEPTH));
    wrap_nx = (idx == IDX_W'(DEPTH - 1)) ? ~wrap : wrap;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx  <= '0;
      wrap <= 1'b0;
    end else if (adv) begin
      idx  <= idx_nx;
      wrap <= wrap_nx;
    end
  end
endmodule

// File: rtl/rob_entries.sv
module rob_entries #(
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 3,
  parameter int DEST_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                alloc_en,
  input  logic [IDX_W-1:0]    alloc_idx,
  input  rob_pkg::rob_kind_e  alloc_kind,
  input  logic [DEST_W-1:0]   alloc_dest,
  input  logic                wb_en,
  input  logic [IDX_W-1:0]    wb_idx,
  input  logic [DATA_W-1:0]   wb_data,
  input  logic [IDX_W-1:0]    rd_idx,
  output rob_pkg::rob_kind_e  rd_kind,
  output logic [DEST_W-1:0]   rd_dest,
  output logic [DATA_W-1:0]   rd_data,
  output logic                rd_fin
);
  import rob_pkg::*;

  rob_kind_e         kind_q [DEPTH];
  logic [DEST_W-1:0] dest_q [DEPTH];
  logic [DATA_W-1:0] val_q  [DEPTH];
  logic [DEPTH-1:0]  fin_q;
  logic [DEPTH-1:0]  hit_alloc;
  logic [DEPTH-1:0]  hit_wb;

  for (genvar g = 0; g < DEPTH; g++) begin : g_dec
    assign hit_alloc[g] = alloc_en && (alloc_idx == IDX_W'(g));
    assign hit_wb[g]    = wb_en && (wb_idx == IDX_W'(g));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fin_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        kind_q[i] <= KIND_REG;
        dest_q[i] <= '0;
        val_q[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (hit_alloc[i]) begin
          fin_q[i]  <= 1'b0;
          kind_q[i] <= alloc_kind;
          dest_q[i] <= alloc_dest;
        end else if (hit_wb[i]) begin
          fin_q[i]  <= 1'b1;
          val_q[i]  <= wb_data;
        end
      end
    end
  end

  assign rd_kind = kind_q[rd_idx];
  assign rd_dest = dest_q[rd_idx];
  assign rd_data = val_q[rd_idx];
  assign rd_fin  = fin_q[rd_idx];
endmodule

// File: rtl/rob_commit_route.sv
module rob_commit_route #(
  parameter int DEST_W = 8,
  parameter int DATA_W = 32
) (
  input  logic               fire,
  input  rob_pkg::rob_kind_e kind,
  input  logic [DEST_W-1:0]  dest,
  input  logic [DATA_W-1:0]  data,
  output logic               arf_we,
  output logic [DEST_W-1:0]  arf_addr,
  output logic [DATA_W-1:0]  arf_data,
  output logic               mem_we,
  output logic [DEST_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_data
);
  import rob_pkg::*;

  always_comb begin
    arf_we   = fire && (kind == KIND_REG);
    mem_we   = fire && (kind == KIND_STORE);
    arf_addr = dest;
    arf_data = data;
    mem_addr = dest;
    mem_data = data;
  end
endmodule

// File: rtl/rob_core.sv
module rob_core #(
  parameter  int DEPTH  = 8,
  parameter  int DEST_W = 8,
  parameter  int DATA_W = 32,
  localparam int TAG_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rs_avail,
  input  logic              alloc_valid,
  input  logic              alloc_kind,
  input  logic [DEST_W-1:0] alloc_dest,
  output logic              alloc_ready,
  output logic [TAG_W-1:0]  alloc_tag,
  input  logic              wb_valid,
  input  logic [TAG_W-1:0]  wb_tag,
  input  logic [DATA_W-1:0] wb_value,
  output logic              arf_we,
  output logic [DEST_W-1:0] arf_addr,
  output logic [DATA_W-1:0] arf_data,
  output logic              mem_we,
  output logic [DEST_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data
);
  import rob_pkg::*;

  localparam int CNT_W = TAG_W + 1;

  logic [TAG_W-1:0]  head_idx, tail_idx;
  logic              head_wrap, tail_wrap;
  logic              rob_full, rob_empty;
  logic              alloc_fire, commit_fire;
  logic              head_fin;
  rob_kind_e         head_kind;
  logic [DEST_W-1:0] head_dest;
  logic [DATA_W-1:0] head_data;
  logic [CNT_W-1:0]  occupancy;

  assign rob_empty   = (head_idx == tail_idx) && (head_wrap == tail_wrap);
  assign rob_full    = (head_idx == tail_idx) && (head_wrap != tail_wrap);
  assign alloc_ready = !rob_full && rs_avail;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign alloc_tag   = tail_idx;
  assign commit_fire = !rob_empty && head_fin;
  assign occupancy   = CNT_W'(rob_fill(32'(head_idx), head_wrap, 32'(tail_idx), tail_wrap, DEPTH));

  rob_ptr #(.DEPTH(DEPTH), .IDX_W(TAG_W)) u_tail (
    .clk(clk), .rst_n(rst_n), .adv(alloc_fire), .idx(tail_idx), .wrap(tail_wrap)
  );

  rob_ptr #(.DEPTH(DEPTH), .IDX_W(TAG_W)) u_head (
    .clk(clk), .rst_n(rst_n), .adv(commit_fire), .idx(head_idx), .wrap(head_wrap)
  );

  rob_entries #(.DEPTH(DEPTH), .IDX_W(TAG_W), .DEST_W(DEST_W), .DATA_W(DATA_W)) u_entries (
    .clk(clk), .rst_n(rst_n),
    .alloc_en(alloc_fire), .alloc_idx(tail_idx),
    .alloc_kind(rob_kind_e'(alloc_kind)), .alloc_dest(alloc_dest),
    .wb_en(wb_valid), .wb_idx(wb_tag), .wb_data(wb_value),
    .rd_idx(head_idx), .rd_kind(head_kind), .rd_dest(head_dest),
    .rd_data(head_data), .rd_fin(head_fin)
  );

  rob_commit_route #(.DEST_W(DEST_W), .DATA_W(DATA_W)) u_route (
    .fire(commit_fire), .kind(head_kind), .dest(head_dest), .data(head_data),
    .arf_we(arf_we), .arf_addr(arf_addr), .arf_data(arf_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data)
  );
endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
  parameter int TAG_W = 3,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rob_empty,
  input logic             rob_full,
  input logic             alloc_ready,
  input logic             alloc_fire,
  input logic             wb_valid,
  input logic [TAG_W-1:0] wb_tag,
  input logic [TAG_W-1:0] head_idx,
  input logic             head_fin,
  input logic             arf_we,
  input logic             mem_we,
  input logic [CNT_W-1:0] occupancy
);
  a_r5_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    !(arf_we && mem_we));

  a_r1_quiet_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    rob_empty |-> (!arf_we && !mem_we));

  a_r3_block_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    rob_full |-> !alloc_ready);

  a_r7_no_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_tag == head_idx && !head_fin) |-> (!arf_we && !mem_we));

  a_r8_head_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (arf_we || mem_we) |=> (head_idx != $past(head_idx)));

  a_r9_alloc_and_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_fire && (arf_we || mem_we)) |=> $stable(occupancy));
endmodule

bind rob_core rob_core_chk #(.TAG_W(TAG_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rob_empty(rob_empty), .rob_full(rob_full),
  .alloc_ready(alloc_ready), .alloc_fire(alloc_fire), .wb_valid(wb_valid),
  .wb_tag(wb_tag), .head_idx(head_idx), .head_fin(head_fin),
  .arf_we(arf_we), .mem_we(mem_we), .occupancy(occupancy)
);

// File: tb/rob_core_bench.sv
module rob_core_bench;
  localparam int DEPTH = 8;
  localparam int TW    = 3;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        rs_avail = 1;
  logic        alloc_valid = 0;
  logic        alloc_kind = 0;
  logic [7:0]  alloc_dest = 0;
  logic        alloc_ready;
  logic [TW-1:0] alloc_tag;
  logic        wb_valid = 0;
  logic [TW-1:0] wb_tag = 0;
  logic [31:0] wb_value = 0;
  logic        arf_we, mem_we;
  logic [7:0]  arf_addr, mem_addr;
  logic [31:0] arf_data, mem_data;

  rob_core #(.DEPTH(DEPTH), .DEST_W(8), .DATA_W(32)) u_rob_core (.*);

  always #10 clk = ~clk;

  typedef struct packed { logic kind; logic [7:0] dest; logic [31:0] val; } item_t;
  item_t       exp_q[$];
  logic [31:0] tag_val [DEPTH];
  int n_checks = 0, n_err = 0, commit_seen = 0, exp_tail = 0;
  bit done = 0;
  logic [TW-1:0] ctags [DEPTH];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // driver: entered and left just after a rising edge
  task automatic do_alloc(input logic k, input logic [7:0] d, input logic [31:0] v,
                          output logic [TW-1:0] tag);
    alloc_valid = 1; alloc_kind = k; alloc_dest = d;
    #1;
    chk(alloc_ready == 1, "R3 ready", alloc_ready, 1);
    chk(alloc_tag == TW'(exp_tail), "R2 tag", alloc_tag, exp_tail);
    tag = alloc_tag;
    tag_val[alloc_tag] = v;
    exp_q.push_back('{kind: k, dest: d, val: v});
    exp_tail = (exp_tail + 1) % DEPTH;
    @(posedge clk); #1;
    alloc_valid = 0;
  endtask

  task automatic do_wb(input logic [TW-1:0] t);
    wb_valid = 1; wb_tag = t; wb_value = tag_val[t];
    @(posedge clk); #1;
    wb_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor: scoreboard compare at falling edges
  always @(negedge clk) begin
    if (rst_n && !done && (arf_we || mem_we)) begin
      item_t it;
      commit_seen++;
      if (exp_q.size() == 0) chk(0, "R4 unexpected commit", commit_seen, 0);
      else begin
        it = exp_q.pop_front();
        if (it.kind == 1'b0) begin
          chk(arf_we && !mem_we, "R5 port", {arf_we, mem_we}, 2);
          chk(arf_addr == it.dest, "R5 addr", arf_addr, it.dest);
          chk(arf_data == it.val, "R5/R4 data", arf_data, it.val);
        end else begin
          chk(mem_we && !arf_we, "R6 port", {arf_we, mem_we}, 1);
          chk(mem_addr == it.dest, "R6 addr", mem_addr, it.dest);
          chk(mem_data == it.val, "R6/R4 data", mem_data, it.val);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    logic [TW-1:0] t0, t1, t2, tx;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    // R1 reset state
    chk(alloc_ready == 1, "R1 ready", alloc_ready, 1);
    chk(!arf_we && !mem_we, "R1 ports idle", {arf_we, mem_we}, 0);
    chk(alloc_tag == 0, "R1 first tag", alloc_tag, 0);
    @(posedge clk); #1;

    // R2/R4/R5: out-of-order writeback, in-order commit
    do_alloc(0, 8'd3, 32'd100, t0);
    do_alloc(0, 8'd7, 32'd200, t1);
    do_alloc(0, 8'd12, 32'd300, t2);
    do_wb(t2);
    idle(2);
    chk(commit_seen == 0, "R4 young finished waits", commit_seen, 0);
    do_wb(t0);
    do_wb(t1);
    idle(3);
    chk(commit_seen == 3, "R4 all retired", commit_seen, 3);

    // R7: writeback to head commits only next cycle
    do_alloc(0, 8'd9, 32'h55, tx);
    wb_valid = 1; wb_tag = tx; wb_value = tag_val[tx];
    @(negedge clk);
    chk(!arf_we, "R7 no same-cycle commit", arf_we, 0);
    @(posedge clk); #1;
    wb_valid = 0;
    @(negedge clk); #1;
    chk(commit_seen == 4, "R7 commit next cycle", commit_seen, 4);
    @(posedge clk); #1;

    // R6: stores mixed with register writes
    do_alloc(1, 8'h40, 32'hdead, t0);
    do_alloc(0, 8'd5, 32'd9, t1);
    do_alloc(1, 8'h41, 32'd7, t2);
    do_wb(t1);
    do_wb(t0);
    do_wb(t2);
    idle(3);
    chk(commit_seen == 7, "R6 mixed retired", commit_seen, 7);

    // R3/R2: fill across wrap, then blocked
    for (int i = 0; i < DEPTH; i++) do_alloc(0, 8'(20 + i), 32'(1000 + i), ctags[i]);
    chk(alloc_ready == 0, "R3 full blocks", alloc_ready, 0);
    alloc_valid = 1; alloc_dest = 8'hee;
    @(posedge clk); #1;
    alloc_valid = 0;
    // R8: one commit frees one entry
    do_wb(ctags[0]);
    idle(2);
    chk(commit_seen == 8, "R8 single commit", commit_seen, 8);
    chk(alloc_ready == 1, "R8 ready after commit", alloc_ready, 1);
    for (int i = DEPTH - 1; i >= 1; i--) do_wb(ctags[i]);
    idle(10);
    chk(commit_seen == 15, "R3 ignored request made no entry", commit_seen, 15);
    chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);

    // R3: no reservation station slot
    rs_avail = 0;
    #1;
    chk(alloc_ready == 0, "R3 rs busy blocks", alloc_ready, 0);
    alloc_valid = 1;
    @(posedge clk); #1;
    alloc_valid = 0; rs_avail = 1;
    idle(1);

    // R9: allocation in the commit cycle
    do_alloc(0, 8'd30, 32'd777, t0);
    do_wb(t0);
    alloc_valid = 1; alloc_kind = 0; alloc_dest = 8'd31;
    #1;
    chk(arf_we && alloc_ready, "R9 both in one cycle", {arf_we, alloc_ready}, 3);
    chk(alloc_tag == TW'(exp_tail), "R9 tag", alloc_tag, exp_tail);
    t1 = alloc_tag;
    tag_val[t1] = 32'd888;
    exp_q.push_back('{kind: 1'b0, dest: 8'd31, val: 32'd888});
    exp_tail = (exp_tail + 1) % DEPTH;
    @(posedge clk); #1;
    alloc_valid = 0;
    do_wb(t1);
    idle(3);
    chk(commit_seen == 17, "R9 both retired", commit_seen, 17);
    chk(!arf_we && !mem_we, "R9 idle after drain", {arf_we, mem_we}, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule